// File: doc/BRIEF.md
# Mode-Aware Segment Linear Address Unit

This unit turns a segment selection plus an offset into a linear address for a processor that runs in three modes: a legacy 32-bit mode, a compatibility mode (32-bit code under a 64-bit kernel) and a native 64-bit mode. It keeps a hidden base and a hidden limit for each of six segment registers. These are indexed 0 to 5 as ES, CS, SS, DS, FS and GS. For each request it applies the addition and limit rules of the current mode. When the base that takes effect is zero, the adder is bypassed and the offset is passed straight through.

The unit also holds the stack pointer and accepts 32-bit and 64-bit writes to it. On a narrow write, whether the upper half is cleared or kept depends on the mode. A mode change on its own reloads nothing. As a result, a non-zero stack-segment base, or stale upper stack-pointer bits, can change the stack address that is seen after moving between compatibility and 64-bit mode.

Top module: `seg_lin_addr_unit`

## Requirements
- R1: After reset, every segment has base 0 and limit 0xFFFF_FFFF, the stack pointer reads 0, and `rsp_valid` is low.
- R2: A request sampled at a rising edge produces `rsp_valid` high for exactly one cycle after that edge. No response appears without a request.
- R3: In legacy mode (`cpu_mode` = 2'b00) and compatibility mode (2'b01), the address is `(base[31:0] + off[31:0]) mod 2^32`, zero-extended to 64 bits.
- R4: In legacy and compatibility modes, `rsp_fault` is set when `off[31:0]` is greater than the segment limit, and is clear when it is equal to or below the limit. The address is still reported when the fault is set.
- R5: In 64-bit mode (`cpu_mode[1]` = 1), segments 0 to 3 (ES, CS, SS, DS) give an address equal to the full 64-bit offset, whatever base is stored.
- R6: In 64-bit mode, segments 4 and 5 (FS, GS) give `(base + off) mod 2^64`.
- R7: In 64-bit mode, `rsp_fault` is never set for segment indices 0 to 5, whatever the limit is.
- R8: Whenever the base that takes effect is zero, the address equals the mode-truncated offset. This matches what the full addition would give.
- R9: Segment indices 6 and 7 set `rsp_fault` and report the mode-truncated offset. A load to index 6 or 7 changes no segment.
- R10: A load writes base and limit at the clock edge. A request in the same cycle to the same segment sees the old values, and a request in the next cycle sees the new values.
- R11: Changing `cpu_mode` alters neither the stored bases and limits nor the stack pointer. Returning to an earlier mode restores the same addresses.
- R12: In 64-bit mode, a 32-bit stack-pointer write (`sp_wr_wide` = 0) sets bits 63:32 to zero.
- R13: In legacy and compatibility modes, a 32-bit stack-pointer write keeps bits 63:32 unchanged. A 64-bit write replaces all 64 bits in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_mode | input | 2 | 00 legacy, 01 compatibility, 1x 64-bit |
| ld_en | input | 1 | Load strobe for a segment's hidden fields |
| ld_seg | input | 3 | Segment index to load |
| ld_base | input | 64 | Base value to load |
| ld_limit | input | 32 | Limit value to load |
| req_valid | input | 1 | Address request strobe |
| req_seg | input | 3 | Segment index of the request |
| req_off | input | 64 | Offset of the request |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_addr | output | 64 | Linear address |
| rsp_fault | output | 1 | Limit or bad-index fault |
| sp_wr_en | input | 1 | Stack-pointer write strobe |
| sp_wr_wide | input | 1 | 1: 64-bit write, 0: 32-bit write |
| sp_wr_data | input | 64 | Stack-pointer write data |
| sp_q | output | 64 | Current stack pointer |

## Verification
A segment load and an address request can land in the same cycle, on the same segment. The bench drives both strobes in one cycle, first for ES and again across a mode change. The scoreboard expects the old base for that response and the new base for the request in the following cycle. A mode switch and a narrow stack-pointer write can also coincide. In that case the new mode must decide how the upper half is treated, and the bench checks the stack pointer one cycle later against values computed under the new mode.

// File: rtl/seg_lau_pkg.sv
// Shared constants for the segment linear address unit.
// Assumes mode encoding 00 legacy, 01 compatibility, 1x 64-bit.
package seg_lau_pkg;
    typedef enum logic [1:0] {
        MODE_LEGACY = 2'b00,
        MODE_COMPAT = 2'b01,
        MODE_LONG   = 2'b10,
        MODE_LONG_X = 2'b11
    } cpu_mode_e;

    localparam int unsigned LONG_BIT = 1;
    localparam logic [2:0]  SEG_FS   = 3'd4;
    localparam logic [2:0]  SEG_GS   = 3'd5;

    // True when the mode word selects 64-bit operation.
    function automatic logic mode_is_long(input logic [1:0] m);
        return m[LONG_BIT];
    endfunction
endpackage

// File: rtl/seg_file.sv
// Hidden base/limit storage for the segment registers.
// Assumes indices at or above NUM_SEG address no register: loads to them
// are dropped and reads report rd_hit = 0. Reads see the pre-edge value.
module seg_file #(
    parameter int unsigned NUM_SEG = 6,
    parameter int unsigned IDX_W   = 3,
    parameter int unsigned BASE_W  = 64,
    parameter int unsigned LIM_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_seg,
    input  logic [BASE_W-1:0] ld_base,
    input  logic [LIM_W-1:0]  ld_limit,
    input  logic [IDX_W-1:0]  rd_seg,
    output logic [BASE_W-1:0] rd_base,
    output logic [LIM_W-1:0]  rd_limit,
    output logic              rd_hit
);
    logic [BASE_W-1:0] base_q  [NUM_SEG];
    logic [LIM_W-1:0]  limit_q [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        // Hold one segment's hidden fields; flat model on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g]  <= '0;
                limit_q[g] <= '1;
            end else if (ld_en && ld_seg == MY_IDX) begin
                base_q[g]  <= ld_base;
                limit_q[g] <= ld_limit;
            end
        end
    end

    // Select the hidden fields of the requested segment.
    always_comb begin
        rd_base  = '0;
        rd_limit = '1;
        rd_hit   = 1'b0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (rd_seg == IDX_W'(i)) begin
                rd_base  = base_q[i];
                rd_limit = limit_q[i];
                rd_hit   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/seg_addr_path.sv
// Mode-dependent linear address formation with a zero-base bypass and
// expand-up limit check; result registered one cycle after the request.
// Assumes rd_* come combinationally from the segment file for req_seg.
module seg_addr_path
    import seg_lau_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned NARR_W = 32,
    parameter int unsigned IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_seg,
    input  logic [ADDR_W-1:0] req_off,
    input  logic [ADDR_W-1:0] rd_base,
    input  logic [NARR_W-1:0] rd_limit,
    input  logic              rd_hit,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_fault
);
    localparam int unsigned PAD_W = ADDR_W - NARR_W;

    logic              is_long;
    logic              keeps_base;
    logic [ADDR_W-1:0] eff_base;
    logic [ADDR_W-1:0] off_m;
    logic [ADDR_W-1:0] sum_full;
    logic [ADDR_W-1:0] sum_m;
    logic              base_zero;
    logic [ADDR_W-1:0] lin_d;
    logic              fault_d;

    // Pick the base that takes effect under the current mode.
    always_comb begin
        is_long    = mode_is_long(mode);
        keeps_base = (req_seg == IDX_W'(SEG_FS)) || (req_seg == IDX_W'(SEG_GS));
        if (!rd_hit)
            eff_base = '0;
        else if (is_long)
            eff_base = keeps_base ? rd_base : '0;
        else
            eff_base = {{PAD_W{1'b0}}, rd_base[NARR_W-1:0]};
    end

    // Form the address: bypass when the base is zero, else add and truncate.
    always_comb begin
        off_m     = is_long ? req_off : {{PAD_W{1'b0}}, req_off[NARR_W-1:0]};
        base_zero = (eff_base == '0);
        sum_full  = off_m + eff_base;
        sum_m     = is_long ? sum_full : {{PAD_W{1'b0}}, sum_full[NARR_W-1:0]};
        lin_d     = base_zero ? off_m : sum_m;
        fault_d   = !rd_hit || (!is_long && (req_off[NARR_W-1:0] > rd_limit));
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_fault <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_addr  <= lin_d;
                rsp_fault <= fault_d;
            end
        end
    end
endmodule

// File: rtl/sp_reg.sv
// Stack pointer register with mode-aware narrow writes.
// Assumes a narrow write zero-extends only in 64-bit mode.
module sp_reg
    import seg_lau_pkg::*;
#(
    parameter int unsigned SP_W   = 64,
    parameter int unsigned NARR_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode,
    input  logic            wr_en,
    input  logic            wr_wide,
    input  logic [SP_W-1:0] wr_data,
    output logic [SP_W-1:0] sp_q
);
    localparam int unsigned HI_W = SP_W - NARR_W;

    logic [HI_W-1:0] hi_d;

    // Choose the upper half for the next write.
    always_comb begin
        if (wr_wide)
            hi_d = wr_data[SP_W-1:NARR_W];
        else if (mode_is_long(mode))
            hi_d = '0;
        else
            hi_d = sp_q[SP_W-1:NARR_W];
    end

    // Update the stack pointer on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= '0;
        else if (wr_en)
            sp_q <= {hi_d, wr_data[NARR_W-1:0]};
    end
endmodule

// File: rtl/seg_lin_addr_unit.sv
// Top of the segment linear address unit: segment file, address path and
// stack pointer. Assumes callers keep loads and requests within one cycle.
module seg_lin_addr_unit #(
    parameter int unsigned ADDR_W  = 64,
    parameter int unsigned NARR_W  = 32,
    parameter int unsigned NUM_SEG = 6,
    parameter int unsigned IDX_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cpu_mode,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_seg,
    input  logic [ADDR_W-1:0] ld_base,
    input  logic [NARR_W-1:0] ld_limit,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_seg,
    input  logic [ADDR_W-1:0] req_off,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_fault,
    input  logic              sp_wr_en,
    input  logic              sp_wr_wide,
    input  logic [ADDR_W-1:0] sp_wr_data,
    output logic [ADDR_W-1:0] sp_q
);
    logic [ADDR_W-1:0] rd_base;
    logic [NARR_W-1:0] rd_limit;
    logic              rd_hit;

    seg_file #(
        .NUM_SEG(NUM_SEG), .IDX_W(IDX_W), .BASE_W(ADDR_W), .LIM_W(NARR_W)
    ) seg_file_i (
        .clk(clk), .rst_n(rst_n),
        .ld_en(ld_en), .ld_seg(ld_seg), .ld_base(ld_base), .ld_limit(ld_limit),
        .rd_seg(req_seg), .rd_base(rd_base), .rd_limit(rd_limit), .rd_hit(rd_hit)
    );

    seg_addr_path #(
        .ADDR_W(ADDR_W), .NARR_W(NARR_W), .IDX_W(IDX_W)
    ) addr_path_i (
        .clk(clk), .rst_n(rst_n), .mode(cpu_mode),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
        .rd_base(rd_base), .rd_limit(rd_limit), .rd_hit(rd_hit),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
    );

    sp_reg #(
        .SP_W(ADDR_W), .NARR_W(NARR_W)
    ) sp_reg_i (
        .clk(clk), .rst_n(rst_n), .mode(cpu_mode),
        .wr_en(sp_wr_en), .wr_wide(sp_wr_wide), .wr_data(sp_wr_data),
        .sp_q(sp_q)
    );
endmodule

// File: rtl/seg_lau_chk.sv
// Property checker for the segment linear address unit, bound to its top.
// Assumes only port-level behaviour; no internal signals are observed.
module seg_lau_chk #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned NARR_W = 32,
    parameter int unsigned IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cpu_mode,
    input logic              req_valid,
    input logic [IDX_W-1:0]  req_seg,
    input logic [ADDR_W-1:0] req_off,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic              rsp_fault,
    input logic              sp_wr_en,
    input logic              sp_wr_wide,
    input logic [ADDR_W-1:0] sp_q
);
    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R3
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cpu_mode[1]) |=> (rsp_addr[ADDR_W-1:NARR_W] == '0));
    // R5
    long_flat_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cpu_mode[1] && req_seg < IDX_W'(4)) |=> (rsp_addr == $past(req_off)));
    // R7
    long_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cpu_mode[1] && req_seg < IDX_W'(6)) |=> !rsp_fault);
    // R9
    bad_index_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_seg >= IDX_W'(6)) |=> rsp_fault);
    // R12
    sp_long_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_wr_en && !sp_wr_wide && cpu_mode[1]) |=> (sp_q[ADDR_W-1:NARR_W] == '0));
    // R13
    sp_narrow_keep_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_wr_en && !sp_wr_wide && !cpu_mode[1]) |=>
            (sp_q[ADDR_W-1:NARR_W] == $past(sp_q[ADDR_W-1:NARR_W])));
endmodule

bind seg_lin_addr_unit seg_lau_chk #(
    .ADDR_W(ADDR_W), .NARR_W(NARR_W), .IDX_W(IDX_W)
) chk_i (.*);

// File: tb/seg_lin_addr_unit_tb.sv
// Scoreboard bench: driver tasks push expected responses into a queue,
// a monitor pops and compares them as responses appear.
module seg_lin_addr_unit_tb_top;
    import seg_lau_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    typedef struct {
        logic [63:0] addr;
        logic        fault;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cpu_mode = MODE_LEGACY;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_seg = '0;
    logic [63:0] ld_base = '0;
    logic [31:0] ld_limit = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_seg = '0;
    logic [63:0] req_off = '0;
    logic        rsp_valid;
    logic [63:0] rsp_addr;
    logic        rsp_fault;
    logic        sp_wr_en = 1'b0;
    logic        sp_wr_wide = 1'b0;
    logic [63:0] sp_wr_data = '0;
    logic [63:0] sp_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [63:0] m_base [8];
    logic [31:0] m_lim  [8];
    logic [63:0] m_sp;
    exp_t        sb_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    seg_lin_addr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_mode(cpu_mode),
        .ld_en(ld_en), .ld_seg(ld_seg), .ld_base(ld_base), .ld_limit(ld_limit),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
        .sp_wr_en(sp_wr_en), .sp_wr_wide(sp_wr_wide), .sp_wr_data(sp_wr_data),
        .sp_q(sp_q)
    );

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance to the next falling edge and drop one-shot strobes.
    task automatic cycle_go();
        @(negedge clk);
        req_valid = 1'b0;
        ld_en     = 1'b0;
        sp_wr_en  = 1'b0;
    endtask

    // Issue a request and push its expected response from the model.
    task automatic issue(input logic [2:0] seg, input logic [63:0] off, input string tag);
        exp_t e;
        logic lng;
        lng = cpu_mode[1];
        if (seg > 3'd5) begin
            e.addr  = lng ? off : {32'b0, off[31:0]};
            e.fault = 1'b1;
        end else if (lng) begin
            e.addr  = (seg >= 3'd4) ? m_base[seg] + off : off;
            e.fault = 1'b0;
        end else begin
            e.addr  = {32'b0, m_base[seg][31:0] + off[31:0]};
            e.fault = off[31:0] > m_lim[seg];
        end
        e.tag = tag;
        sb_q.push_back(e);
        req_valid = 1'b1;
        req_seg   = seg;
        req_off   = off;
    endtask

    // Drive a segment load; the model updates after any same-cycle request.
    task automatic load(input logic [2:0] seg, input logic [63:0] b, input logic [31:0] l);
        ld_en = 1'b1; ld_seg = seg; ld_base = b; ld_limit = l;
        if (seg <= 3'd5) begin
            m_base[seg] = b;
            m_lim[seg]  = l;
        end
    endtask

    // Write the stack pointer and check it one cycle later.
    task automatic sp_write(input logic [63:0] d, input bit wide, input string tag);
        sp_wr_en = 1'b1; sp_wr_wide = wide; sp_wr_data = d;
        if (wide)            m_sp = d;
        else if (cpu_mode[1]) m_sp = {32'b0, d[31:0]};
        else                  m_sp = {m_sp[63:32], d[31:0]};
        cycle_go();
        check64(tag, sp_q, m_sp);
    endtask

    // Monitor: compare each response with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R2 response without request actual=%h expected=none", rsp_addr);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check64({e.tag, " addr"}, rsp_addr, e.addr);
                check64({e.tag, " fault"}, {63'b0, rsp_fault}, {63'b0, e.fault});
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_base[i] = '0;
            m_lim[i]  = '1;
        end
        m_sp = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cycle_go();

        // R1 reset state
        check64("R1 rsp_valid", {63'b0, rsp_valid}, 64'd0);
        check64("R1 sp_q", sp_q, 64'd0);
        for (int s = 0; s < 6; s++) begin
            issue(3'(s), 64'h0000_0000_FFFF_FFFF, "R1 flat");
            cycle_go();
        end
        cycle_go();
        check64("R2 idle", {63'b0, rsp_valid}, 64'd0);

        // Load segment fields
        load(3'd0, 64'h0000_0000_0000_1000, 32'h0000_FFFF); cycle_go();
        load(3'd1, 64'h0000_0000_8000_0000, 32'hFFFF_FFFF); cycle_go();
        load(3'd2, 64'hABCD_0000_0010_0000, 32'h000F_FFFF); cycle_go();
        load(3'd4, 64'h0000_0001_0000_0000, 32'h0000_0010); cycle_go();
        load(3'd5, 64'hFFFF_FFFF_F000_0000, 32'hFFFF_FFFF); cycle_go();

        // Legacy mode: R3, R4, R8, R9 (back-to-back requests also cover R2)
        cpu_mode = MODE_LEGACY;
        issue(3'd0, 64'h2345, "R3 ES add");              cycle_go();
        issue(3'd0, 64'h1_0000, "R4 ES over limit");     cycle_go();
        issue(3'd0, 64'hFFFF, "R4 ES at limit");         cycle_go();
        issue(3'd1, 64'h9000_0000, "R3 CS wrap");        cycle_go();
        issue(3'd2, 64'hF_FFFF, "R4 SS at limit");       cycle_go();
        issue(3'd3, 64'hDEAD_0000_0000_0010, "R8 DS zero base"); cycle_go();
        issue(3'd6, 64'h5555_0000_1234, "R9 index 6");   cycle_go();
        cycle_go();

        // Compatibility mode
        cpu_mode = MODE_COMPAT;
        issue(3'd4, 64'h20, "R4 FS over limit");         cycle_go();
        issue(3'd5, 64'h1000_0010, "R3 GS wrap");        cycle_go();
        issue(3'd2, 64'h20, "R11 SS compat");            cycle_go();

        // 64-bit mode: R5, R6, R7, R8, R9, R11
        cpu_mode = MODE_LONG;
        issue(3'd2, 64'h20, "R11 SS long");              cycle_go();
        issue(3'd0, 64'h1234_5678_9ABC_DEF0, "R5 ES");   cycle_go();
        issue(3'd1, 64'h8000_0000_0000_0001, "R5 CS");   cycle_go();
        issue(3'd4, 64'h5, "R6 FS");                     cycle_go();
        issue(3'd4, 64'h100, "R7 FS beyond limit");      cycle_go();
        issue(3'd5, 64'h2000_0000, "R6 GS wrap");        cycle_go();
        issue(3'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R8 DS long"); cycle_go();
        issue(3'd7, 64'hCAFE_0000_0000_0001, "R9 index 7"); cycle_go();
        cpu_mode = MODE_LONG_X;
        issue(3'd0, 64'h42, "R5 mode 11");               cycle_go();
        cpu_mode = MODE_COMPAT;
        issue(3'd2, 64'h20, "R11 SS back");              cycle_go();

        // R10: same-cycle load and request
        cpu_mode = MODE_LEGACY;
        issue(3'd0, 64'h10, "R10 old ES");
        load(3'd0, 64'h5000, 32'hFFFF_FFFF);             cycle_go();
        issue(3'd0, 64'h10, "R10 new ES");               cycle_go();
        load(3'd6, 64'h777, 32'h0);                      cycle_go();
        issue(3'd6, 64'h10, "R9 load 6 ignored");        cycle_go();
        issue(3'd0, 64'h10, "R9 ES untouched");          cycle_go();
        cpu_mode = MODE_LONG;
        issue(3'd4, 64'h1, "R10 old FS");
        load(3'd4, 64'h0, 32'h0);                        cycle_go();
        issue(3'd4, 64'h1, "R8 FS zero base");           cycle_go();
        cycle_go();

        // Stack pointer: R12, R13, R11
        cpu_mode = MODE_LONG;
        sp_write(64'h1234_5678_0000_0000, 1'b1, "R13 wide long");
        sp_write(64'hFFFF_FFFF_9ABC_DEF0, 1'b0, "R12 narrow long");
        cpu_mode = MODE_COMPAT;
        sp_write(64'h1234_5678_1111_1111, 1'b1, "R13 wide compat");
        sp_write(64'hFFFF_FFFF_9ABC_DEF0, 1'b0, "R13 narrow compat");
        cpu_mode = MODE_LONG;
        cycle_go();
        check64("R11 sp after mode switch", sp_q, 64'h1234_5678_9ABC_DEF0);
        cpu_mode = MODE_LEGACY;
        sp_write(64'h0000_0000_0000_0ABC, 1'b0, "R13 narrow legacy");
        cpu_mode = MODE_LONG;
        sp_write(64'h5555_5555_0000_0040, 1'b0, "R12 switch and write");

        repeat (3) cycle_go();
        checks++;
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL R2 missing responses actual=%0d expected=0", sb_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule